// File: doc/BRIEF.md
# Windowed Register File with Main-Memory Mirror

This block sits between a small 8-bit CPU core and its main memory. It serves byte and word accesses over a 16-bit data space. The lowest sixteen addresses do not go to main memory for reads. Instead they reach a 264-byte internal register RAM, at an offset set by a window-pointer byte. The pointer is masked with `0xF8` and the address is added to it. The pointer is itself a memory-mapped byte at address `0x1E`.

Every write to one of the sixteen low addresses lands in the register RAM and also goes out to main memory at the same low address. A debugger or DMA engine that looks at main memory addresses `0x00`–`0x0F` therefore always sees the active registers. When the pointer changes, the block copies the sixteen bytes of the new window into that mirror range, one byte per cycle. While this copy runs, a busy flag is held and the CPU port is closed.

The CPU issues one access while `cpu_ready` is high. The block performs it one byte per cycle on its main-memory port, which has a combinational read. It pulses `cpu_done` when the access is complete. Upper address bits beyond 16 are dropped.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, every register RAM byte is 0, `cpu_ready` is 1, and `win_busy`, `cpu_done` and `mem_en` are 0.
- R2: A read of address N < 16 returns register RAM byte `(ptr & 0xF8) + N` and never drives a main-memory read (`mem_en` high with `mem_we` low) to an address below 16.
- R3: A write of address N < 16 stores the byte at register RAM index `(ptr & 0xF8) + N` and, in the same cycle, writes the same byte to main memory address N.
- R4: Reads and writes of addresses 16 and above go to main memory at that address and leave the register RAM unchanged.
- R5: Only bits 15:0 of `cpu_addr` are used; higher bits have no effect on the access.
- R6: Word accesses are big-endian: bits 15:8 of the word sit at the given address and bits 7:0 at address+1, modulo 2^16. Byte reads return the byte in `cpu_rdata[7:0]` with bits 15:8 zero.
- R7: A byte written to address `0x1E` becomes the window pointer for every later byte access, including the second byte of the same word, and is also written to main memory at `0x1E`.
- R8: With the pointer at or above `0xF8`, the window spans register RAM indices `0xF8` to `0x107` without wrapping onto indices `0x00`–`0x0F`.
- R9: After a pointer write, `win_busy` is high for 16 cycles counted from the `cpu_done` pulse. During those cycles main-memory addresses 0 to 15 are written in ascending order with the new window's bytes. An access that does not write the pointer causes no busy period.
- R10: An access is accepted on a clock edge where `cpu_req` and `cpu_ready` are high. `cpu_ready` is low while the access is in progress. `cpu_done` is high in the second cycle after acceptance for a byte access and in the third cycle for a word access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit big-endian access, 0 = byte |
| cpu_addr | input | CPU_AW | Byte address; only bits 15:0 are used |
| cpu_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid while `cpu_done` is high |
| win_busy | output | 1 | Mirror refresh after a pointer change is running |
| mem_en | output | 1 | Main-memory access strobe |
| mem_we | output | 1 | Main-memory write enable |
| mem_addr | output | 16 | Main-memory byte address |
| mem_wdata | output | 8 | Main-memory write data |
| mem_rdata | input | 8 | Main-memory read data, combinational from `mem_addr` |

## Verification
Some properties are checked on every cycle. No main-memory read is ever issued to the low window. Each register RAM write is paired with a mirror write to the same low address carrying the same byte. A pointer write is always followed by the busy flag. The refresh offset steps by one per free cycle and holds when the CPU engine has the port. The second byte of a word always follows the first. Other behaviour is only visible through the bench's scenarios: which RAM index a window address reaches, the absence of wrap above pointer `0xF8`, big-endian ordering across the `0xFFFF` wrap, truncation of the upper address bits, and the exact mirror contents and busy length after a pointer change.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

   localparam int unsigned BUS_AW = 16;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 2 * BYTE_W;

   typedef logic [BUS_AW-1:0] bus_addr_t;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;

   // One CPU-side access as latched by the sequencer.
   typedef struct packed {
      logic      wr;
      logic      wide;
      bus_addr_t addr;
      word_t     data;
   } cpu_op_t;

   // Owner of the main-memory port in a given cycle.
   typedef enum logic [1:0] {
      SRC_NONE    = 2'd0,
      SRC_CPU     = 2'd1,
      SRC_REFRESH = 2'd2
   } port_src_e;

endpackage

// File: rtl/winreg_bank.sv
module winreg_bank
   import winreg_pkg::*;
#(
   parameter int unsigned RAM_BYTES   = 264,
   parameter int unsigned WIN_BYTES   = 16,
   parameter logic [7:0]  PTR_MASK    = 8'hF8,
   parameter bit          WRAP_WINDOW = 1'b0,
   localparam int unsigned IDX_W      = $clog2(RAM_BYTES),
   localparam int unsigned OFF_W      = $clog2(WIN_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  byte_t            ptr_i,
   input  logic             wr_en_i,
   input  logic [OFF_W-1:0] wr_off_i,
   input  byte_t            wr_data_i,
   input  logic [OFF_W-1:0] rd_a_off_i,
   output byte_t            rd_a_data_o,
   input  logic [OFF_W-1:0] rd_b_off_i,
   output byte_t            rd_b_data_o
);

   localparam int unsigned N_PORTS = 3;

   if (WRAP_WINDOW && RAM_BYTES < 256) begin : g_bad_wrap
      $error("winreg_bank: wrapping window needs at least 256 bytes");
   end
   if (!WRAP_WINDOW && RAM_BYTES < int'(PTR_MASK) + WIN_BYTES) begin : g_bad_flat
      $error("winreg_bank: RAM too small for highest masked pointer plus window");
   end

   byte_t            mem_q [RAM_BYTES];
   logic [OFF_W-1:0] off_v [N_PORTS];
   logic [IDX_W-1:0] idx_v [N_PORTS];
   byte_t            base8;

   assign base8    = ptr_i & PTR_MASK;
   assign off_v[0] = rd_a_off_i;
   assign off_v[1] = rd_b_off_i;
   assign off_v[2] = wr_off_i;

   // Index adder per port; the variant decides whether the window wraps at 256.
   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      if (WRAP_WINDOW) begin : g_wrap
         byte_t sum8;
         assign sum8     = base8 + BYTE_W'(off_v[p]);
         assign idx_v[p] = IDX_W'(sum8);
      end else begin : g_flat
         assign idx_v[p] = IDX_W'(base8) + IDX_W'(off_v[p]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(RAM_BYTES); i++) mem_q[i] <= '0;
      end else if (wr_en_i) begin
         mem_q[idx_v[2]] <= wr_data_i;
      end
   end

   assign rd_a_data_o = mem_q[idx_v[0]];
   assign rd_b_data_o = mem_q[idx_v[1]];

   // R4: without a write, an unchanged pointer and offset read the same byte.
   p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en_i) && $stable(ptr_i) && $stable(rd_a_off_i)) |-> $stable(rd_a_data_o));

endmodule

// File: rtl/winreg_seq.sv
module winreg_seq
   import winreg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_i,
   input  cpu_op_t   op_i,
   input  logic      hold_i,
   output logic      ready_o,
   output logic      done_o,
   output word_t     rdata_o,
   output logic      acc_valid_o,
   output logic      acc_we_o,
   output bus_addr_t acc_addr_o,
   output byte_t     acc_wdata_o,
   input  byte_t     acc_rdata_i
);

   cpu_op_t op_q;
   logic    act_q;
   logic    ph_q;
   logic    done_q;
   word_t   rdata_q;
   logic    last;

   assign ready_o     = !act_q && !hold_i;
   assign acc_valid_o = act_q;
   assign acc_we_o    = op_q.wr;
   assign acc_addr_o  = op_q.addr + BUS_AW'(ph_q);
   assign acc_wdata_o = (op_q.wide && !ph_q) ? op_q.data[WORD_W-1:BYTE_W]
                                             : op_q.data[BYTE_W-1:0];
   assign last        = !op_q.wide || ph_q;
   assign done_o      = done_q;
   assign rdata_o     = rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= '0;
         act_q   <= 1'b0;
         ph_q    <= 1'b0;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!act_q) begin
            if (req_i && !hold_i) begin
               act_q <= 1'b1;
               ph_q  <= 1'b0;
               op_q  <= op_i;
            end
         end else begin
            if (!op_q.wr) begin
               if (!op_q.wide)    rdata_q <= {{BYTE_W{1'b0}}, acc_rdata_i};
               else if (!ph_q)    rdata_q[WORD_W-1:BYTE_W] <= acc_rdata_i;
               else               rdata_q[BYTE_W-1:0]      <= acc_rdata_i;
            end
            if (last) begin
               act_q  <= 1'b0;
               ph_q   <= 1'b0;
               done_q <= 1'b1;
            end else begin
               ph_q <= 1'b1;
            end
         end
      end
   end

   // R6: the low byte of a word always follows its high byte at address+1.
   p_word_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && op_q.wide && !ph_q) |=> (act_q && ph_q && $stable(op_q.addr)));

   // R10: an accepted request starts its first byte phase on the next cycle.
   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && ready_o) |=> (act_q && !ph_q));

   // R10: completion is reported only right after the last byte phase.
   p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!act_q && $past(act_q)));

endmodule

// File: rtl/winreg_mirror.sv
module winreg_mirror #(
   parameter int unsigned WIN_BYTES = 16,
   localparam int unsigned OFF_W    = $clog2(WIN_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stall_i,
   output logic             busy_o,
   output logic             wr_o,
   output logic [OFF_W-1:0] off_o
);

   localparam logic [OFF_W-1:0] LAST = OFF_W'(WIN_BYTES - 1);

   logic             busy_q;
   logic [OFF_W-1:0] cnt_q;

   assign busy_o = busy_q;
   assign wr_o   = busy_q && !stall_i;
   assign off_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (wr_o) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R9: each free busy cycle moves the copy to the next mirror byte.
   p_refresh_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !stall_i && !start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

   // R9: while the CPU engine owns the port the copy position holds.
   p_refresh_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && stall_i && !start_i) |=> (busy_q && $stable(cnt_q)));

endmodule

// File: rtl/winreg_file.sv
module winreg_file
   import winreg_pkg::*;
#(
   parameter int unsigned CPU_AW      = 24,
   parameter int unsigned RAM_BYTES   = 264,
   parameter int unsigned WIN_BYTES   = 16,
   parameter logic [7:0]  PTR_MASK    = 8'hF8,
   parameter logic [15:0] PTR_ADDR    = 16'h001E,
   parameter bit          WRAP_WINDOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              cpu_word,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [15:0]       cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [15:0]       cpu_rdata,
   output logic              win_busy,
   output logic              mem_en,
   output logic              mem_we,
   output logic [15:0]       mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);

   localparam int unsigned OFF_W = $clog2(WIN_BYTES);

   if (CPU_AW < BUS_AW) begin : g_bad_aw
      $error("winreg_file: CPU address narrower than the 16-bit data space");
   end
   if (WIN_BYTES < 2 || WIN_BYTES > 256 || (1 << OFF_W) != WIN_BYTES) begin : g_bad_win
      $error("winreg_file: window size must be a power of two from 2 to 256");
   end
   if (int'(PTR_ADDR) < WIN_BYTES) begin : g_bad_ptr
      $error("winreg_file: pointer byte must lie outside the window");
   end

   // Bits above the 16-bit data space are dropped on purpose.
   if (CPU_AW > BUS_AW) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^cpu_addr[CPU_AW-1:BUS_AW];
   end

   cpu_op_t          op_in;
   logic             acc_valid;
   logic             acc_we;
   bus_addr_t        acc_addr;
   byte_t            acc_wdata;
   byte_t            acc_rdata;
   logic             is_win;
   logic             bank_we;
   logic             ptr_we;
   byte_t            ptr_q;
   byte_t            bank_rd_a;
   byte_t            bank_rd_b;
   logic             ref_wr;
   logic [OFF_W-1:0] ref_off;
   port_src_e        src;

   assign op_in = '{wr: cpu_we, wide: cpu_word, addr: cpu_addr[BUS_AW-1:0], data: cpu_wdata};

   winreg_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (cpu_req),
      .op_i        (op_in),
      .hold_i      (win_busy),
      .ready_o     (cpu_ready),
      .done_o      (cpu_done),
      .rdata_o     (cpu_rdata),
      .acc_valid_o (acc_valid),
      .acc_we_o    (acc_we),
      .acc_addr_o  (acc_addr),
      .acc_wdata_o (acc_wdata),
      .acc_rdata_i (acc_rdata)
   );

   assign is_win  = acc_addr < BUS_AW'(WIN_BYTES);
   assign bank_we = acc_valid && acc_we && is_win;
   assign ptr_we  = acc_valid && acc_we && (acc_addr == PTR_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr_q <= '0;
      else if (ptr_we) ptr_q <= acc_wdata;
   end

   winreg_bank #(
      .RAM_BYTES   (RAM_BYTES),
      .WIN_BYTES   (WIN_BYTES),
      .PTR_MASK    (PTR_MASK),
      .WRAP_WINDOW (WRAP_WINDOW)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .ptr_i       (ptr_q),
      .wr_en_i     (bank_we),
      .wr_off_i    (acc_addr[OFF_W-1:0]),
      .wr_data_i   (acc_wdata),
      .rd_a_off_i  (acc_addr[OFF_W-1:0]),
      .rd_a_data_o (bank_rd_a),
      .rd_b_off_i  (ref_off),
      .rd_b_data_o (bank_rd_b)
   );

   winreg_mirror #(
      .WIN_BYTES (WIN_BYTES)
   ) u_mirror (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (ptr_we),
      .stall_i (acc_valid),
      .busy_o  (win_busy),
      .wr_o    (ref_wr),
      .off_o   (ref_off)
   );

   assign acc_rdata = is_win ? bank_rd_a : mem_rdata;

   always_comb begin
      if (acc_valid)   src = SRC_CPU;
      else if (ref_wr) src = SRC_REFRESH;
      else             src = SRC_NONE;
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (src)
         SRC_CPU: begin
            mem_en    = acc_we || !is_win;
            mem_we    = acc_we;
            mem_addr  = acc_addr;
            mem_wdata = acc_wdata;
         end
         SRC_REFRESH: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = BUS_AW'(ref_off);
            mem_wdata = bank_rd_b;
         end
         default: ;
      endcase
   end

   // R2: the window is never fetched from main memory.
   p_win_no_mem_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |-> (mem_addr >= BUS_AW'(WIN_BYTES)));

   // R3: a register RAM write is mirrored to the same low address with the same byte.
   p_mirror_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> (mem_en && mem_we && mem_addr == BUS_AW'(acc_addr[OFF_W-1:0]) && mem_wdata == acc_wdata));

   // R9: a pointer write always opens a refresh period on the next cycle.
   p_ptr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |=> win_busy);

   // R10: the CPU port is closed for the whole refresh.
   p_ready_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      win_busy |-> !cpu_ready);

endmodule

// File: tb/winreg_file_bench.sv
module winreg_file_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic        cpu_word = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ready, cpu_done, win_busy;
   logic [15:0] cpu_rdata;
   logic        mem_en, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   winreg_file u_winreg_file (
      .clk (clk), .rst_n (rst_n),
      .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_word (cpu_word),
      .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
      .cpu_ready (cpu_ready), .cpu_done (cpu_done), .cpu_rdata (cpu_rdata),
      .win_busy (win_busy),
      .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
   );

   // Sparse main memory: pages 0x0000-0x0FFF and 0xF000-0xFFFF.
   logic [7:0] mm     [8192];
   logic [7:0] ex_mm  [8192];
   logic [7:0] ex_rf  [264];
   logic [7:0] ex_ptr;
   int checks = 0;
   int fails = 0;
   int low_reads = 0;

   function automatic int mi(input logic [15:0] a);
      return int'({a[15], a[11:0]});
   endfunction

   assign mem_rdata = mm[mi(mem_addr)];

   always @(posedge clk) begin
      if (mem_en && mem_we) mm[mi(mem_addr)] <= mem_wdata;
      if (rst_n && mem_en && !mem_we && mem_addr < 16'd16) low_reads++;
   end

   function automatic int m_base();
      return int'(ex_ptr & 8'hF8);
   endfunction

   function automatic logic [7:0] m_rd(input logic [15:0] a);
      if (a < 16'd16) return ex_rf[m_base() + int'(a)];
      return ex_mm[mi(a)];
   endfunction

   task automatic m_wr(input logic [15:0] a, input logic [7:0] d);
      if (a < 16'd16) ex_rf[m_base() + int'(a)] = d;
      ex_mm[mi(a)] = d;
      if (a == 16'h001E) begin
         ex_ptr = d;
         for (int i = 0; i < 16; i++) ex_mm[i] = ex_rf[m_base() + i];
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic we, input logic word, input logic [23:0] a,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output int lat, output int blen);
      while (!cpu_ready) @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_word = word; cpu_addr = a; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      chk("R10 ready low while busy with access", {31'd0, cpu_ready}, 32'd0);
      lat = 1;
      while (!cpu_done) begin @(negedge clk); lat++; end
      rd = cpu_rdata;
      blen = 0;
      while (win_busy) begin blen++; @(negedge clk); end
   endtask

   task automatic do_op(input logic we, input logic word, input logic [23:0] a,
                        input logic [15:0] wd, input string tag);
      logic [15:0] a16, exp_rd, rd;
      int lat, blen;
      bit ptr_hit;
      a16 = a[15:0];
      exp_rd = word ? {m_rd(a16), m_rd(a16 + 16'd1)} : {8'h00, m_rd(a16)};
      ptr_hit = we && (a16 == 16'h001E || (word && (a16 + 16'd1) == 16'h001E));
      run_op(we, word, a, wd, rd, lat, blen);
      chk({tag, " R10 latency"}, lat, word ? 32'd3 : 32'd2);
      if (!we) begin
         chk({tag, " read data"}, {16'd0, rd}, {16'd0, exp_rd});
      end else begin
         m_wr(a16, word ? wd[15:8] : wd[7:0]);
         if (word) m_wr(a16 + 16'd1, wd[7:0]);
         chk({tag, " R3 R4 main memory byte"}, {24'd0, mm[mi(a16)]}, {24'd0, ex_mm[mi(a16)]});
         if (ptr_hit) begin
            chk({tag, " R9 busy length"}, blen, 32'd16);
            for (int i = 0; i < 16; i++)
               chk({tag, " R9 mirror byte"}, {24'd0, mm[i]}, {24'd0, ex_mm[i]});
         end else begin
            chk({tag, " R9 no refresh"}, blen, 32'd0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      for (int i = 0; i < 8192; i++) begin
         mm[i] = 8'($urandom);
         ex_mm[i] = mm[i];
      end
      for (int i = 0; i < 264; i++) ex_rf[i] = 8'h00;
      ex_ptr = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle reset state
      chk("R1 ready after reset", {31'd0, cpu_ready}, 32'd1);
      chk("R1 busy after reset", {31'd0, win_busy}, 32'd0);
      chk("R1 done after reset", {31'd0, cpu_done}, 32'd0);
      chk("R1 mem_en after reset", {31'd0, mem_en}, 32'd0);
      for (int i = 0; i < 16; i++) do_op(1'b0, 1'b0, 24'(i), 16'h0, "R1 R2 cleared window");

      // R3 write-through, R2 read back
      do_op(1'b1, 1'b0, 24'h000005, 16'h00A5, "R3 window write");
      do_op(1'b0, 1'b0, 24'h000005, 16'h0, "R2 window read");
      // R7 move window, old value no longer visible
      do_op(1'b1, 1'b0, 24'h00001E, 16'h0013, "R7 pointer write");
      do_op(1'b0, 1'b0, 24'h000005, 16'h0, "R7 new window read");
      do_op(1'b0, 1'b0, 24'h00001E, 16'h0, "R7 pointer readback");
      // R8 top window, no wrap
      do_op(1'b1, 1'b0, 24'h00001E, 16'h00FF, "R8 pointer high");
      for (int i = 0; i < 16; i++) do_op(1'b1, 1'b0, 24'(i), 16'(8'h80 + i), "R8 fill top window");
      do_op(1'b1, 1'b0, 24'h00001E, 16'h0000, "R8 pointer zero");
      for (int i = 0; i < 16; i++) do_op(1'b0, 1'b0, 24'(i), 16'h0, "R8 bottom window intact");
      do_op(1'b1, 1'b0, 24'h00001E, 16'h00FB, "R8 pointer masked");
      for (int i = 0; i < 16; i++) do_op(1'b0, 1'b0, 24'(i), 16'h0, "R8 top window readback");
      // R5 truncation
      do_op(1'b1, 1'b0, 24'hAB0020, 16'h005C, "R5 upper bits write");
      do_op(1'b0, 1'b0, 24'h7F0020, 16'h0, "R5 upper bits read");
      do_op(1'b0, 1'b0, 24'hC30003, 16'h0, "R5 upper bits window");
      // R6 big-endian words, including 0xFFFF wrap into the window
      do_op(1'b1, 1'b1, 24'h00000E, 16'h1234, "R6 word write window");
      do_op(1'b0, 1'b0, 24'h00000E, 16'h0, "R6 high byte first");
      do_op(1'b0, 1'b0, 24'h00000F, 16'h0, "R6 low byte second");
      do_op(1'b1, 1'b1, 24'h00FFFF, 16'hBEEF, "R6 word wrap write");
      do_op(1'b0, 1'b1, 24'h00FFFF, 16'h0, "R6 word wrap read");
      do_op(1'b0, 1'b1, 24'h00000F, 16'h0, "R6 word across window edge");
      // R7 pointer written by the low byte of a word
      do_op(1'b1, 1'b1, 24'h00001D, 16'h7728, "R7 word sets pointer");
      do_op(1'b1, 1'b1, 24'h00001E, 16'h4011, "R7 word high byte pointer");
      do_op(1'b0, 1'b1, 24'h000000, 16'h0, "R7 word read new window");

      // Random mix
      for (int k = 0; k < 400; k++) begin
         logic [15:0] a;
         logic we, word;
         int sel;
         sel = int'($urandom % 10);
         we = 1'($urandom);
         word = 1'($urandom);
         case (sel)
            0: begin a = 16'h001E; we = 1'b1; word = 1'b0; end
            1, 2, 3, 4: a = 16'($urandom % 16);
            5, 6: a = 16'h0010 + 16'($urandom % 32);
            7: a = 16'h0100 + 16'($urandom % 16'h0F00);
            default: a = 16'hF000 + 16'($urandom % 16'h1000);
         endcase
         do_op(we, word, {8'($urandom), a}, 16'($urandom), "R2 R4 R6 random");
      end

      chk("R2 no main-memory read of window", low_reads, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule